// File: doc/BRIEF.md
# Debug Domain Access Controller

This controller decides which debug sub-domains of a device are open. Every domain has a fixed manufacturing policy with three meaningful settings: never open, open only after a successful authentication, or always open. The policy arrives on a tie-off input and the block never writes it. A host unlocks the conditional domains through a short handshake over a command port. It sends a start command. The device answers with a 128-bit challenge taken from an external random source. The host then returns a response. That response carries the echoed challenge, a credential unique ID, a key index, a grant mask with one bit per domain, and the pass/fail verdict of an external signature verifier.

A response is accepted only if all of the following hold: it arrives while the controller is waiting for one, the echoed challenge matches, the verifier passed, the key index is not marked revoked, and, when the policy demands it, the credential ID equals the device ID. On acceptance the grant mask is latched and the authenticated flag is set. Any rejected or misplaced response clears both. Each domain enable is then formed from its policy code, the authenticated flag and its latched grant bit.

Top module: `dbgacc_top`

## Requirements
- R1: Out of reset the authenticated flag is 0, the challenge strobe is 0, and only domains whose policy code is always-open are enabled.
- R2: Policy codes are 2 bits per domain, with domain i at bits [2i+1:2i]. 2'b10 enables the domain unconditionally. 2'b00 and 2'b11 keep it disabled even when the flag is set and the grant bit is 1. 2'b01 enables it only when the flag is set and that domain's latched grant bit is 1.
- R3: A start command (cmdCode 2'b01 with cmdValid) sampled on one edge raises chalValid for exactly the following cycle. chalData then shows the value of rngData sampled with the start, and it holds that value until the next start.
- R4: A response (cmdCode 2'b10) sampled while waiting, one cycle or more after the challenge cycle, sets authOk on that edge when all checks pass, and latches respGrant as the grant mask.
- R5: A response whose echoed challenge differs from chalData is rejected: authOk is 0 after that edge.
- R6: A response with respSigOk low is rejected.
- R7: A response whose key index selects a set bit of revokedKeys is rejected.
- R8: With uidCheckReq high, a response whose respUid differs from devUid is rejected. With uidCheckReq low, the ID is not compared.
- R9: A response sampled while not waiting (idle, or during the challenge cycle) clears authOk and the grant mask. A later response is also rejected until a new start is sent.
- R10: A start command clears authOk and the grant mask on the same edge that captures the challenge.
- R11: cmdCode values 2'b00 and 2'b11 have no effect on authOk, domEn or chalValid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| policyCfg | input | 2*NUM_DOM | Fixed per-domain policy codes |
| uidCheckReq | input | 1 | Policy demands credential ID match |
| devUid | input | UID_W | Device unique ID |
| revokedKeys | input | 2**KEY_W | One bit per key index, 1 = revoked |
| rngData | input | CHAL_W | Random value captured as challenge |
| cmdValid | input | 1 | Command strobe |
| cmdCode | input | 2 | 01 start, 10 response, others ignored |
| respChal | input | CHAL_W | Challenge echoed by host |
| respUid | input | UID_W | Credential unique ID |
| respKeyIdx | input | KEY_W | Credential key index |
| respSigOk | input | 1 | External signature verifier verdict |
| respGrant | input | NUM_DOM | Credential grant bit per domain |
| chalValid | output | 1 | Challenge present this cycle |
| chalData | output | CHAL_W | Current challenge |
| authOk | output | 1 | Authenticated flag |
| domEn | output | NUM_DOM | Per-domain enable |

## Verification
The assertions assume that the response fields and the verifier verdict are valid in the cycle where cmdValid carries a response code, and that policyCfg does not change after reset. The stimulus holds policyCfg at one constant pattern that covers all four codes. It changes response fields only together with a command, and it moves rngData away from the captured value right after each start, so a stale or late capture shows up as a challenge mismatch.

// File: rtl/dbgacc_pkg.sv
package dbgacc_pkg;
  typedef enum logic [1:0] {
    POL_OFF  = 2'b00,
    POL_AUTH = 2'b01,
    POL_ON   = 2'b10,
    POL_RSVD = 2'b11
  } polCode_e;

  localparam logic [1:0] CMD_START = 2'b01;
  localparam logic [1:0] CMD_RESP  = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_CHAL = 2'b01,
    ST_WAIT = 2'b10
  } state_e;

  typedef struct packed {
    logic captureChal;
    logic grantAuth;
    logic clearAuth;
  } dpStrobe_t;
endpackage

// File: rtl/dbgacc_ctrl.sv
module dbgacc_ctrl
  import dbgacc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdCode,
  input  logic       respOk,
  output dpStrobe_t  strobe,
  output logic       chalValid,
  output logic       waiting
);
  state_e state, nextState;
  logic isStart, isResp;

  assign isStart = cmdValid && (cmdCode == CMD_START);
  assign isResp  = cmdValid && (cmdCode == CMD_RESP);

  always_comb begin
    nextState = state;
    strobe    = '0;
    if (isStart) begin
      nextState          = ST_CHAL;
      strobe.captureChal = 1'b1;
      strobe.clearAuth   = 1'b1;
    end else if (isResp) begin
      nextState = ST_IDLE;
      if (state == ST_WAIT && respOk) strobe.grantAuth = 1'b1;
      else                            strobe.clearAuth = 1'b1;
    end else if (state == ST_CHAL) begin
      nextState = ST_WAIT;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign chalValid = (state == ST_CHAL);
  assign waiting   = (state == ST_WAIT);

  // R3
  start_chal_chk: assert property (@(posedge clk) disable iff (!rstN)
    isStart |=> chalValid);

  // R3
  chal_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chalValid && !isStart) |=> !chalValid);
endmodule

// File: rtl/dbgacc_datapath.sv
module dbgacc_datapath
  import dbgacc_pkg::*;
#(
  parameter int NUM_DOM = 10,
  parameter int CHAL_W  = 128,
  parameter int UID_W   = 64,
  parameter int KEY_W   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  dpStrobe_t             strobe,
  input  logic [2*NUM_DOM-1:0]  policyCfg,
  input  logic                  uidCheckReq,
  input  logic [UID_W-1:0]      devUid,
  input  logic [(1<<KEY_W)-1:0] revokedKeys,
  input  logic [CHAL_W-1:0]     rngData,
  input  logic [CHAL_W-1:0]     respChal,
  input  logic [UID_W-1:0]      respUid,
  input  logic [KEY_W-1:0]      respKeyIdx,
  input  logic                  respSigOk,
  input  logic [NUM_DOM-1:0]    respGrant,
  output logic                  respOk,
  output logic [CHAL_W-1:0]     chalData,
  output logic                  authOk,
  output logic [NUM_DOM-1:0]    domEn
);
  logic [CHAL_W-1:0]  chalReg;
  logic               authReg;
  logic [NUM_DOM-1:0] grantReg;
  logic chalMatch, uidPass, keyLive;

  assign chalMatch = (respChal == chalReg);
  assign uidPass   = !uidCheckReq || (respUid == devUid);
  assign keyLive   = !revokedKeys[respKeyIdx];
  assign respOk    = chalMatch && respSigOk && keyLive && uidPass;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chalReg  <= '0;
      authReg  <= 1'b0;
      grantReg <= '0;
    end else begin
      if (strobe.captureChal) chalReg <= rngData;
      if (strobe.clearAuth) begin
        authReg  <= 1'b0;
        grantReg <= '0;
      end else if (strobe.grantAuth) begin
        authReg  <= 1'b1;
        grantReg <= respGrant;
      end
    end
  end

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    polCode_e pol;
    assign pol = polCode_e'(policyCfg[2*i +: 2]);
    assign domEn[i] = (pol == POL_ON) ||
                      ((pol == POL_AUTH) && authReg && grantReg[i]);
  end

  assign chalData = chalReg;
  assign authOk   = authReg;

  // R4
  auth_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(authReg) |-> $past(strobe.grantAuth));
endmodule

// File: rtl/dbgacc_top.sv
module dbgacc_top
  import dbgacc_pkg::*;
#(
  parameter int NUM_DOM = 10,
  parameter int CHAL_W  = 128,
  parameter int UID_W   = 64,
  parameter int KEY_W   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [2*NUM_DOM-1:0]  policyCfg,
  input  logic                  uidCheckReq,
  input  logic [UID_W-1:0]      devUid,
  input  logic [(1<<KEY_W)-1:0] revokedKeys,
  input  logic [CHAL_W-1:0]     rngData,
  input  logic                  cmdValid,
  input  logic [1:0]            cmdCode,
  input  logic [CHAL_W-1:0]     respChal,
  input  logic [UID_W-1:0]      respUid,
  input  logic [KEY_W-1:0]      respKeyIdx,
  input  logic                  respSigOk,
  input  logic [NUM_DOM-1:0]    respGrant,
  output logic                  chalValid,
  output logic [CHAL_W-1:0]     chalData,
  output logic                  authOk,
  output logic [NUM_DOM-1:0]    domEn
);
  dpStrobe_t strobe;
  logic respOk, waiting;

  dbgacc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .respOk(respOk), .strobe(strobe), .chalValid(chalValid), .waiting(waiting)
  );

  dbgacc_datapath #(
    .NUM_DOM(NUM_DOM), .CHAL_W(CHAL_W), .UID_W(UID_W), .KEY_W(KEY_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .policyCfg(policyCfg),
    .uidCheckReq(uidCheckReq), .devUid(devUid), .revokedKeys(revokedKeys),
    .rngData(rngData), .respChal(respChal), .respUid(respUid),
    .respKeyIdx(respKeyIdx), .respSigOk(respSigOk), .respGrant(respGrant),
    .respOk(respOk), .chalData(chalData), .authOk(authOk), .domEn(domEn)
  );

  // R9
  ooo_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_RESP && !waiting) |=> !authOk);

  // R10
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdCode == CMD_START) |=> !authOk);

  // R3
  chal_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdValid && cmdCode == CMD_START) |=> $stable(chalData));
endmodule

// File: tb/dbgacc_top_tb.sv
module dbgacc_top_tb;
  localparam int ND = 10;
  localparam logic [2*ND-1:0] POLICY = {{7{2'b01}}, 2'b11, 2'b00, 2'b10};
  localparam logic [7:0]  REVOKED = 8'b0010_0000;
  localparam logic [63:0] DEV_UID = 64'hC0FF_EE12_3456_789A;

  typedef struct packed {
    logic          uidReq;
    logic          badChal;
    logic          sigOk;
    logic [2:0]    key;
    logic          badUid;
    logic [ND-1:0] grant;
    logic          expAuth;
    logic [3:0]    tag;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 10'h3FF, 1'b1, 4'd4},
    '{1'b1, 1'b1, 1'b1, 3'd1, 1'b0, 10'h3FF, 1'b0, 4'd5},
    '{1'b1, 1'b0, 1'b0, 3'd2, 1'b0, 10'h3FF, 1'b0, 4'd6},
    '{1'b1, 1'b0, 1'b1, 3'd5, 1'b0, 10'h3FF, 1'b0, 4'd7},
    '{1'b1, 1'b0, 1'b1, 3'd3, 1'b1, 10'h3FF, 1'b0, 4'd8},
    '{1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 10'h2AA, 1'b1, 4'd8},
    '{1'b1, 1'b0, 1'b1, 3'd7, 1'b0, 10'h055, 1'b1, 4'd2},
    '{1'b0, 1'b0, 1'b1, 3'd6, 1'b0, 10'h000, 1'b1, 4'd4}
  };

  logic clk = 0, rstN = 0;
  logic uidCheckReq = 0, cmdValid = 0, respSigOk = 0;
  logic [1:0] cmdCode = 0;
  logic [127:0] rngData = 0, respChal = 0, chalData;
  logic [63:0] respUid = 0;
  logic [2:0] respKeyIdx = 0;
  logic [ND-1:0] respGrant = 0, domEn;
  logic chalValid, authOk;
  int nVec = 0, nFail = 0;

  always #5 clk = ~clk;

  dbgacc_top u_dut (
    .clk(clk), .rstN(rstN), .policyCfg(POLICY), .uidCheckReq(uidCheckReq),
    .devUid(DEV_UID), .revokedKeys(REVOKED), .rngData(rngData),
    .cmdValid(cmdValid), .cmdCode(cmdCode), .respChal(respChal),
    .respUid(respUid), .respKeyIdx(respKeyIdx), .respSigOk(respSigOk),
    .respGrant(respGrant), .chalValid(chalValid), .chalData(chalData),
    .authOk(authOk), .domEn(domEn)
  );

  function automatic string reqName(input logic [3:0] t);
    case (t)
      4'd2: return "R2";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [ND-1:0] expDom(input logic a, input logic [ND-1:0] g);
    logic [ND-1:0] r = '0;
    for (int i = 0; i < ND; i++) begin
      case (POLICY[2*i +: 2])
        2'b10:   r[i] = 1'b1;
        2'b01:   r[i] = a & g[i];
        default: r[i] = 1'b0;
      endcase
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    nVec++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // at a negedge: drive start; returns at the negedge of the challenge cycle
  task automatic sendStart(input logic [127:0] r);
    cmdValid = 1; cmdCode = 2'b01; rngData = r;
    @(negedge clk);
    cmdValid = 0; rngData = ~r;
  endtask

  // drive response now; returns at next negedge, after the sampling edge
  task automatic respond(input logic [127:0] ch, input logic sig, input logic [2:0] k,
                         input logic [63:0] uid, input logic [ND-1:0] g);
    cmdValid = 1; cmdCode = 2'b10; respChal = ch; respSigOk = sig;
    respKeyIdx = k; respUid = uid; respGrant = g;
    @(negedge clk);
    cmdValid = 0; respSigOk = 0;
  endtask

  task automatic goodAuth(input logic [ND-1:0] g);
    logic [127:0] r = {$urandom, $urandom, $urandom, $urandom};
    uidCheckReq = 1;
    sendStart(r);
    @(negedge clk);
    respond(r, 1'b1, 3'd0, DEV_UID, g);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", authOk, 0);
    chk("R1", chalValid, 0);
    chk("R1", domEn, expDom(1'b0, '0));
    rstN = 1;
    @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      logic [127:0] r = {$urandom, $urandom, $urandom, $urandom};
      uidCheckReq = VEC[v].uidReq;
      sendStart(r);
      chk("R3", chalValid, 1);
      chk("R3", chalData, r);
      @(negedge clk);
      chk("R3", chalValid, 0);
      chk("R3", chalData, r);
      respond(VEC[v].badChal ? r ^ 128'h1 : r, VEC[v].sigOk, VEC[v].key,
              VEC[v].badUid ? DEV_UID ^ 64'h8 : DEV_UID, VEC[v].grant);
      chk(reqName(VEC[v].tag), authOk, VEC[v].expAuth);
      chk("R2", domEn, expDom(VEC[v].expAuth, VEC[v].grant));
    end

    // R11 undefined command codes ignored
    goodAuth(10'h3F0);
    cmdValid = 1; cmdCode = 2'b11; @(negedge clk);
    cmdCode = 2'b00; @(negedge clk);
    cmdValid = 0;
    chk("R11", authOk, 1);
    chk("R11", chalValid, 0);
    chk("R11", domEn, expDom(1'b1, 10'h3F0));

    // R9 response while idle clears authentication
    respond(chalData, 1'b1, 3'd0, DEV_UID, 10'h3FF);
    chk("R9", authOk, 0);
    chk("R9", domEn, expDom(1'b0, '0));

    // R9 response during the challenge cycle, then a late response
    begin
      logic [127:0] r = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_1357_9BDF;
      uidCheckReq = 1;
      sendStart(r);
      respond(r, 1'b1, 3'd0, DEV_UID, 10'h3FF);
      chk("R9", authOk, 0);
      chk("R9", chalValid, 0);
      @(negedge clk);
      respond(r, 1'b1, 3'd0, DEV_UID, 10'h3FF);
      chk("R9", authOk, 0);
      chk("R9", domEn, expDom(1'b0, '0));
    end

    // R10 new start drops an existing authentication
    goodAuth(10'h3FF);
    chk("R4", authOk, 1);
    sendStart(128'h5);
    chk("R10", authOk, 0);
    chk("R10", domEn, expDom(1'b0, '0));
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", nVec, nFail);
    $finish;
  end
endmodule